// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a set of active-high, level-sensitive interrupt request lines from peripherals and forwards the most urgent eligible one to the processor on a single interrupt output. When the processor acknowledges, the block delivers a vector number for the chosen source. It then marks that source as being serviced. The processor later retires it with an end-of-interrupt strobe.

Fixed priority applies: line 0 is the most urgent and the highest line number the least. The controller keeps a pending set, a mask set and an in-service set. A pending, unmasked request raises the interrupt output only when it outranks every source already in service, so handlers nest only when a more urgent source arrives. A separate non-maskable input reaches the processor directly and ignores the mask and in-service state.

The vector delivered on acknowledge is a parameterised base plus the line number. It stays on the vector output until the next accepted acknowledge.

Top module: `irq_ctrl_top`

## Requirements
- R1: A request line held high during a clock edge sets its pending bit at that edge, and the bit stays set after the line drops until the request is acknowledged.
- R2: Among pending unmasked requests, the lowest-numbered line is the one signalled and acknowledged.
- R3: A pulse on `maskWr` loads `maskData` into the mask set, where bit value 1 masks that line. A masked line never raises `intOut` and is never acknowledged, but its pending bit is kept, so clearing the mask later raises `intOut`.
- R4: When `intAck` is high while `intOut` is high, the selected line at that clock edge moves from pending to in-service, and from the next cycle `vecOut` equals VEC_BASE + line number (VEC_BASE defaults to 0x20).
- R5: A pending unmasked request whose line number is lower than every in-service line raises `intOut`, even while other handlers are in service.
- R6: A request whose line number is equal to or greater than that of any in-service line is held pending and keeps `intOut` low.
- R7: A pulse on `eoiWr` clears the lowest-numbered in-service bit. When nothing is in service, it has no effect.
- R8: A line still high at the edge where its request is acknowledged becomes pending again at the following edge.
- R9: `nmiOut` follows `nmiIn` combinationally, whatever the mask and in-service state.
- R10: During and after reset, the pending, mask and in-service sets are empty, `vecOut` is 0 and `intOut` is low.
- R11: When `intAck` is high while `intOut` is low, it is ignored: `vecOut` and the in-service set are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | NUM_LINES | Level-sensitive request lines, line 0 most urgent |
| nmiIn | input | 1 | Non-maskable request |
| intAck | input | 1 | Processor acknowledge, one cycle |
| eoiWr | input | 1 | End-of-interrupt strobe, one cycle |
| maskWr | input | 1 | Mask load strobe |
| maskData | input | NUM_LINES | New mask, 1 = masked |
| intOut | output | 1 | Interrupt request to the processor |
| vecOut | output | VEC_W | Vector of the last accepted acknowledge |
| nmiOut | output | 1 | Non-maskable request to the processor |

## Verification
The assertions assume that `intAck`, `eoiWr` and `maskWr` are single-cycle strobes. They also assume that an end-of-interrupt strobe is never given in the same cycle as an accepted acknowledge, so the count of in-service bits drops by exactly one per retire. The stimulus follows these rules. It raises each strobe for exactly one clock and lowers it at the next falling edge. Retires are always issued in cycles separate from acknowledges. Request lines change only away from the rising edge, which keeps the level-sensitive capture deterministic.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef struct packed {
    logic ackTake;   // accepted acknowledge this cycle
    logic eoiTake;   // end-of-interrupt with something in service
    logic maskLoad;  // load new mask
  } irqStrobes_t;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] reqVec,
  output logic                 anySet,
  output logic [IDX_W-1:0]     topIdx
);

  // lowest index wins; scan from the top so the last hit is the lowest
  always_comb begin
    anySet = |reqVec;
    topIdx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (reqVec[i]) topIdx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_ctrl_ctl.sv
module irq_ctrl_ctl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] pendQ,
  input  logic [NUM_LINES-1:0] maskQ,
  input  logic [NUM_LINES-1:0] isrQ,
  input  logic                 intAck,
  input  logic                 eoiWr,
  input  logic                 maskWr,
  output irqStrobes_t          strb,
  output logic [IDX_W-1:0]     ackIdx,
  output logic [IDX_W-1:0]     eoiIdx,
  output logic                 intOut
);

  logic [NUM_LINES-1:0] eligible;
  logic                 winAny;
  logic                 isrAny;

  assign eligible = pendQ & ~maskQ;

  irq_prio_enc #(.NUM_LINES(NUM_LINES)) uWinEnc (
    .reqVec(eligible),
    .anySet(winAny),
    .topIdx(ackIdx)
  );

  irq_prio_enc #(.NUM_LINES(NUM_LINES)) uIsrEnc (
    .reqVec(isrQ),
    .anySet(isrAny),
    .topIdx(eoiIdx)
  );

  // raise only when the winner outranks everything in service
  always_comb begin
    intOut = winAny && (!isrAny || (ackIdx < eoiIdx));
    strb.ackTake  = intAck && intOut;
    strb.eoiTake  = eoiWr && isrAny;
    strb.maskLoad = maskWr;
  end

  AST_NEST_ONLY_HIGHER: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> ((isrQ & ((NUM_LINES'(2) << ackIdx) - NUM_LINES'(1))) == '0)); // R5

  AST_MASKED_NEVER_SIGNALS: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> (!maskQ[ackIdx] && pendQ[ackIdx])); // R3

endmodule

// File: rtl/irq_ctrl_dp.sv
module irq_ctrl_dp
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 8,
  parameter int VEC_BASE  = 32,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqReq,
  input  logic [NUM_LINES-1:0] maskData,
  input  irqStrobes_t          strb,
  input  logic [IDX_W-1:0]     ackIdx,
  input  logic [IDX_W-1:0]     eoiIdx,
  output logic [NUM_LINES-1:0] pendQ,
  output logic [NUM_LINES-1:0] maskQ,
  output logic [NUM_LINES-1:0] isrQ,
  output logic [VEC_W-1:0]     vecOut
);

  logic [NUM_LINES-1:0] ackHot;
  logic [NUM_LINES-1:0] eoiHot;

  assign ackHot = strb.ackTake ? (NUM_LINES'(1) << ackIdx) : '0;
  assign eoiHot = strb.eoiTake ? (NUM_LINES'(1) << eoiIdx) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ  <= '0;
      maskQ  <= '0;
      isrQ   <= '0;
      vecOut <= '0;
    end else begin
      // acknowledged bit is cleared this edge; a held line re-arms next edge
      pendQ <= (pendQ | irqReq) & ~ackHot;
      isrQ  <= (isrQ & ~eoiHot) | ackHot;
      if (strb.maskLoad) maskQ <= maskData;
      if (strb.ackTake) vecOut <= VEC_W'(VEC_BASE) + VEC_W'(ackIdx);
    end
  end

  AST_ACK_MOVES_BIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackTake |=> (isrQ[$past(ackIdx)] && !pendQ[$past(ackIdx)])); // R4

  AST_VEC_FROM_LINE: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackTake |=> (vecOut == VEC_W'(VEC_BASE) + VEC_W'($past(ackIdx)))); // R4

  AST_VEC_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ackTake |=> $stable(vecOut)); // R11

  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoiTake && !strb.ackTake) |=> ($countones(isrQ) + 1 == $countones($past(isrQ)))); // R7

endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 8,
  parameter int VEC_BASE  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqReq,
  input  logic                 nmiIn,
  input  logic                 intAck,
  input  logic                 eoiWr,
  input  logic                 maskWr,
  input  logic [NUM_LINES-1:0] maskData,
  output logic                 intOut,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 nmiOut
);

  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  irqStrobes_t          strb;
  logic [IDX_W-1:0]     ackIdx;
  logic [IDX_W-1:0]     eoiIdx;
  logic [NUM_LINES-1:0] pendQ;
  logic [NUM_LINES-1:0] maskQ;
  logic [NUM_LINES-1:0] isrQ;

  // non-maskable path bypasses all state
  assign nmiOut = nmiIn;

  irq_ctrl_ctl #(.NUM_LINES(NUM_LINES)) uCtl (
    .clk(clk), .rstN(rstN),
    .pendQ(pendQ), .maskQ(maskQ), .isrQ(isrQ),
    .intAck(intAck), .eoiWr(eoiWr), .maskWr(maskWr),
    .strb(strb), .ackIdx(ackIdx), .eoiIdx(eoiIdx), .intOut(intOut)
  );

  irq_ctrl_dp #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) uDp (
    .clk(clk), .rstN(rstN),
    .irqReq(irqReq), .maskData(maskData),
    .strb(strb), .ackIdx(ackIdx), .eoiIdx(eoiIdx),
    .pendQ(pendQ), .maskQ(maskQ), .isrQ(isrQ), .vecOut(vecOut)
  );

endmodule

// File: tb/tb_irq_ctrl_top.sv
`timescale 1ns/1ps
module tb_irq_ctrl_top;

  localparam int NL = 8;
  localparam int VW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NL-1:0] irqReq = '0;
  logic          nmiIn = 1'b0;
  logic          intAck = 1'b0;
  logic          eoiWr = 1'b0;
  logic          maskWr = 1'b0;
  logic [NL-1:0] maskData = '0;
  logic          intOut;
  logic [VW-1:0] vecOut;
  logic          nmiOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    string req;
    int    sel;   // 0 intOut, 1 vecOut, 2 nmiOut
    int    exp;
  } expItem_t;

  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  irq_ctrl_top #(.NUM_LINES(NL), .VEC_W(VW), .VEC_BASE(32)) dut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .nmiIn(nmiIn),
    .intAck(intAck), .eoiWr(eoiWr), .maskWr(maskWr), .maskData(maskData),
    .intOut(intOut), .vecOut(vecOut), .nmiOut(nmiOut)
  );

  // scoreboard monitor: compares queued expectations just after each falling edge
  always begin
    @(negedge clk);
    #1;
    while (expQ.size() > 0) begin
      expItem_t it;
      int act;
      it = expQ.pop_front();
      act = (it.sel == 0) ? int'(intOut) : (it.sel == 1) ? int'(vecOut) : int'(nmiOut);
      total++;
      if (act != it.exp) begin
        bad++;
        $display("FAIL %s sig=%0d actual=%0h expected=%0h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expectSig(string req, int sel, int exp);
    expQ.push_back('{req, sel, exp});
  endtask

  // advance to the next falling edge and drop one-cycle strobes
  task automatic tick();
    @(negedge clk);
    intAck = 1'b0;
    eoiWr  = 1'b0;
    maskWr = 1'b0;
  endtask

  task automatic settle();
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    expectSig("R10 reset intOut", 0, 0);
    expectSig("R10 reset vecOut", 1, 0);
    settle();
    rstN = 1'b1;
    tick();
    expectSig("R10 after reset intOut", 0, 0);
    expectSig("R9 nmi idle", 2, 0);
    settle();

    // simultaneous requests on lines 3 and 5
    irqReq = 8'b0010_1000;
    tick();
    expectSig("R1 R2 pending raises intOut", 0, 1);
    settle();
    intAck = 1'b1;
    tick();
    expectSig("R4 R2 vector of line 3", 1, 32'h23);
    expectSig("R6 line 5 blocked by 3", 0, 0);
    settle();
    tick();
    expectSig("R6 equal priority re-armed but held", 0, 0);
    settle();
    irqReq = '0;
    intAck = 1'b1;
    tick();
    expectSig("R11 ack while low keeps vector", 1, 32'h23);
    expectSig("R11 ack while low intOut", 0, 0);
    settle();
    eoiWr = 1'b1;
    tick();
    expectSig("R7 R8 retire then re-armed line 3", 0, 1);
    settle();
    intAck = 1'b1;
    tick();
    expectSig("R8 re-armed line 3 acked", 1, 32'h23);
    settle();
    eoiWr = 1'b1;
    tick();
    expectSig("R1 line 5 still pending", 0, 1);
    settle();
    intAck = 1'b1;
    tick();
    expectSig("R4 vector of line 5", 1, 32'h25);
    settle();
    eoiWr = 1'b1;
    tick();
    expectSig("R7 all retired", 0, 0);
    settle();

    // masking of line 2
    maskData = 8'b0000_0100;
    maskWr = 1'b1;
    tick();
    settle();
    irqReq = 8'b0000_0100;
    tick();
    irqReq = '0;
    expectSig("R3 masked line silent", 0, 0);
    settle();
    intAck = 1'b1;
    tick();
    expectSig("R3 masked line not acked", 1, 32'h25);
    settle();
    maskData = '0;
    maskWr = 1'b1;
    tick();
    expectSig("R3 unmask raises kept pending", 0, 1);
    settle();
    intAck = 1'b1;
    tick();
    expectSig("R3 vector of line 2", 1, 32'h22);
    settle();
    eoiWr = 1'b1;
    tick();
    settle();

    // nested preemption
    irqReq = 8'b0100_0000;
    tick();
    irqReq = '0;
    settle();
    intAck = 1'b1;
    tick();
    expectSig("R4 vector of line 6", 1, 32'h26);
    settle();
    irqReq = 8'b0000_0010;
    tick();
    irqReq = '0;
    expectSig("R5 line 1 preempts 6", 0, 1);
    settle();
    intAck = 1'b1;
    tick();
    expectSig("R5 vector of line 1", 1, 32'h21);
    settle();
    irqReq = 8'b0001_0000;
    tick();
    irqReq = '0;
    expectSig("R6 line 4 blocked by 1", 0, 0);
    settle();
    eoiWr = 1'b1;
    tick();
    expectSig("R7 retire cleared line 1 so 4 outranks 6", 0, 1);
    settle();
    intAck = 1'b1;
    tick();
    expectSig("R5 vector of line 4", 1, 32'h24);
    settle();
    eoiWr = 1'b1;
    tick();
    settle();
    eoiWr = 1'b1;
    tick();
    settle();
    eoiWr = 1'b1;
    tick();
    expectSig("R7 retire on empty ignored", 0, 0);
    settle();
    irqReq = 8'b1000_0000;
    tick();
    irqReq = '0;
    expectSig("R7 nothing left in service", 0, 1);
    settle();
    intAck = 1'b1;
    tick();
    expectSig("R2 vector of line 7", 1, 32'h27);
    settle();
    eoiWr = 1'b1;
    tick();
    settle();

    // non-maskable bypass
    maskData = 8'hFF;
    maskWr = 1'b1;
    tick();
    settle();
    irqReq = 8'b0000_0001;
    nmiIn = 1'b1;
    tick();
    expectSig("R9 nmi passes with all masked", 2, 1);
    expectSig("R3 line 0 masked", 0, 0);
    settle();
    nmiIn = 1'b0;
    irqReq = '0;
    tick();
    expectSig("R9 nmi released", 2, 0);
    settle();

    tick();
    settle();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule